// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block is the digital sequencer behind a multi-rail regulator's start-up and protection. Power-on is reported by two supply-good flags. Once both flags are high, and no external shutdown or inhibit request is present, the block produces a soft-start level. That level is a counter. On its first running cycle it jumps to one quarter of full scale, and it then climbs by a fixed step every clock until it reaches full scale. A completion flag marks the moment the ramp has finished while the rails are being driven.

Protection events come in two kinds. An overcurrent trip, or an undervoltage on a linear rail once the ramp has finished, does three things:
- it disables drive;
- it lets the level finish its climb to full scale, then drops it to zero for one cycle, and then starts a fresh ramp;
- it adds one to a retry count.

The third such trip latches a fault. An overvoltage latches the fault at once. A latched fault holds every output off. Only a power-on reset releases it: one of the supply flags falls, or the synchronous reset is applied. The same event also clears the retry count.

Top module: `ss_fault_seq`

## Requirements
- R1: While `bias_ok` or `aux_ok` is low, the next clock edge leaves `ss_level` at 0, `drv_off` at 1, `ss_done` at 0 and `fault` at 0.
- R2: On the first edge at which both supply flags are high, `shdn_n` is high and `inhibit` is low, `ss_level` becomes FULL/4 and `drv_off` falls to 0. Each later running edge adds STEP, saturating at FULL. `ss_done` is 1 exactly when running at FULL.
- R3: `luv` has no effect while `ss_done` is 0.
- R4: `luv` seen high while `ss_done` is 1 counts as one overcurrent event.
- R5: A trip is sampled on one edge and acts on the next edge in the running state. It sets `drv_off`, and the level continues stepping up to FULL. On the edge after FULL is reached, the level reads 0 for one cycle. A new ramp then starts at FULL/4.
- R6: The third counted event latches `fault` (1). While the fault is latched, `ss_level` is 0, `drv_off` is 1 and `ss_done` is 0.
- R7: `ov` seen high with both supplies good latches `fault` on that edge, regardless of the retry count.
- R8: A latched fault survives shutdown and inhibit. Only a low supply flag or `rst_n` low clears it, together with the retry count.
- R9: `shdn_n` low or `inhibit` high returns `ss_level` to 0 with `drv_off` 1 on the next edge, and keeps the retry count. Releasing the request restarts the ramp at FULL/4.
- R10: An overcurrent held high across retries counts once per retry, so a persistent overload reaches the fault after three ramps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on threshold |
| aux_ok | input | 1 | Second monitored supply above its threshold |
| shdn_n | input | 1 | External shutdown, active low |
| inhibit | input | 1 | Inhibit request decoded from the voltage code |
| oc | input | 1 | Overcurrent comparator level |
| ov | input | 1 | Main-rail overvoltage comparator level |
| luv | input | 1 | Linear-rail undervoltage level |
| ss_level | output | SSW | Soft-start level |
| ss_done | output | 1 | Ramp complete while running |
| drv_off | output | 1 | Disable for all output drivers |
| fault | output | 1 | Latched fault |

## Verification
The bench builds the block with SSW=5, FULL=16 and STEP=5. With these values the ramp reads 4, 9, 14 and then 16, so it passes through a saturating step in only four cycles. A complete retry fits in about seven cycles, which puts three consecutive retries and the fault latch within one short vector table. The table also reaches:
- a trip that arrives mid-ramp;
- a trip that arrives at full scale;
- undervoltage blanking;
- retry counts carried across shutdown and cleared by supply loss.

// File: rtl/ss_fault_seq.sv
module ss_fault_seq #(
  parameter int SSW      = 10,
  parameter int FULL     = 1000,
  parameter int STEP     = 4,
  parameter int OC_LIMIT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bias_ok,
  input  logic           aux_ok,
  input  logic           shdn_n,
  input  logic           inhibit,
  input  logic           oc,
  input  logic           ov,
  input  logic           luv,
  output logic [SSW-1:0] ss_level,
  output logic           ss_done,
  output logic           drv_off,
  output logic           fault
);
  localparam logic [SSW-1:0] FULL_V = SSW'(FULL);
  localparam logic [SSW-1:0] INIT_V = SSW'(FULL / 4);
  localparam logic [SSW-1:0] STEP_V = SSW'(STEP);
  localparam int             CW     = $clog2(OC_LIMIT + 1);
  localparam logic [CW-1:0]  LAST   = CW'(OC_LIMIT - 1);

  typedef enum logic [2:0] {S_OFF, S_RUN, S_PEND, S_DIS, S_FLT} st_t;

  st_t           st;
  logic [SSW-1:0] ss;
  logic [CW-1:0]  cnt;
  logic           trip_q;
  logic [SSW:0]   sum;
  logic [SSW-1:0] ramp;
  logic           por_ok;

  assign por_ok = bias_ok & aux_ok;
  assign sum    = {1'b0, ss} + {1'b0, STEP_V};
  assign ramp   = (sum >= {1'b0, FULL_V}) ? FULL_V : sum[SSW-1:0];

  assign ss_level = ss;
  assign ss_done  = (st == S_RUN) && (ss == FULL_V);
  assign drv_off  = (st != S_RUN);
  assign fault    = (st == S_FLT);

  always_ff @(posedge clk) begin
    if (!rst_n || !por_ok) begin
      st     <= S_OFF;
      ss     <= '0;
      cnt    <= '0;
      trip_q <= 1'b0;
    end else begin
      trip_q <= oc | (luv & ss_done);
      if (st == S_FLT) begin
        ss <= '0;
      end else if (ov) begin
        st <= S_FLT;
        ss <= '0;
      end else if (!shdn_n || inhibit) begin
        st <= S_OFF;
        ss <= '0;
      end else begin
        unique case (st)
          S_OFF: begin
            st <= S_RUN;
            ss <= INIT_V;
          end
          S_RUN: begin
            if (trip_q) begin
              if (cnt == LAST) begin
                st <= S_FLT;
                ss <= '0;
              end else begin
                st <= S_PEND;
                ss <= ramp;
              end
              cnt <= cnt + 1'b1;
            end else begin
              ss <= ramp;
            end
          end
          S_PEND: begin
            if (ss == FULL_V) begin
              st <= S_DIS;
              ss <= '0;
            end else begin
              ss <= ramp;
            end
          end
          S_DIS: begin
            st <= S_RUN;
            ss <= INIT_V;
          end
          default: begin
            st <= S_FLT;
            ss <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ss_fault_seq_chk.sv
module ss_fault_seq_chk #(
  parameter int SSW  = 10,
  parameter int FULL = 1000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bias_ok,
  input logic           aux_ok,
  input logic           shdn_n,
  input logic           inhibit,
  input logic           ov,
  input logic [SSW-1:0] ss_level,
  input logic           ss_done,
  input logic           drv_off,
  input logic           fault
);
  a_r1_por_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_ok && aux_ok) |=> (ss_level == '0 && drv_off && !fault && !ss_done));

  a_r2_ramp_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_off && $past(!drv_off)) |-> (ss_level >= $past(ss_level)));

  a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (ss_level == '0 && drv_off && !ss_done));

  a_r7_ov_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && bias_ok && aux_ok) |=> fault);

  a_r8_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && bias_ok && aux_ok) |=> fault);

  a_r9_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_n || inhibit) |=> (ss_level == '0 && drv_off));
endmodule

bind ss_fault_seq ss_fault_seq_chk #(.SSW(SSW), .FULL(FULL)) u_chk (
  .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .aux_ok(aux_ok),
  .shdn_n(shdn_n), .inhibit(inhibit), .ov(ov), .ss_level(ss_level),
  .ss_done(ss_done), .drv_off(drv_off), .fault(fault)
);

// File: tb/tb_ss_fault_seq.sv
module tb_ss_fault_seq;
  localparam int SSW = 5;

  logic clk = 1'b0;
  logic rst_n, bias_ok, aux_ok, shdn_n, inhibit, oc, ov, luv;
  logic [SSW-1:0] ss_level;
  logic ss_done, drv_off, fault;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ss_fault_seq #(.SSW(SSW), .FULL(16), .STEP(5), .OC_LIMIT(3)) dut (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .aux_ok(aux_ok),
    .shdn_n(shdn_n), .inhibit(inhibit), .oc(oc), .ov(ov), .luv(luv),
    .ss_level(ss_level), .ss_done(ss_done), .drv_off(drv_off), .fault(fault)
  );

  // {req, bias aux shdn_n inh oc ov luv, ss, done off fault}
  localparam int NV = 42;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1,  7'b0110000, 5'd0,  3'b010}, // R1
    {4'd1,  7'b1010000, 5'd0,  3'b010}, // R1
    {4'd2,  7'b1110000, 5'd4,  3'b000}, // R2 jump
    {4'd3,  7'b1110001, 5'd9,  3'b000}, // R3 blanked
    {4'd3,  7'b1110001, 5'd14, 3'b000}, // R3
    {4'd2,  7'b1110000, 5'd16, 3'b100}, // R2 saturate
    {4'd2,  7'b1110000, 5'd16, 3'b100},
    {4'd5,  7'b1110100, 5'd16, 3'b100}, // R5 sampled
    {4'd5,  7'b1110000, 5'd16, 3'b010}, // R5 acts
    {4'd5,  7'b1110000, 5'd0,  3'b010},
    {4'd5,  7'b1110000, 5'd4,  3'b000},
    {4'd10, 7'b1110100, 5'd9,  3'b000}, // R10
    {4'd5,  7'b1110100, 5'd14, 3'b010}, // R5 ramp continues
    {4'd5,  7'b1110100, 5'd16, 3'b010},
    {4'd5,  7'b1110100, 5'd0,  3'b010},
    {4'd10, 7'b1110100, 5'd4,  3'b000},
    {4'd6,  7'b1110100, 5'd0,  3'b011}, // R6 third
    {4'd8,  7'b1101000, 5'd0,  3'b011}, // R8 sticky
    {4'd8,  7'b0110000, 5'd0,  3'b010}, // R8 cleared
    {4'd8,  7'b1110000, 5'd4,  3'b000},
    {4'd7,  7'b1110010, 5'd0,  3'b011}, // R7
    {4'd1,  7'b1010000, 5'd0,  3'b010},
    {4'd2,  7'b1110000, 5'd4,  3'b000},
    {4'd2,  7'b1110000, 5'd9,  3'b000},
    {4'd2,  7'b1110000, 5'd14, 3'b000},
    {4'd2,  7'b1110000, 5'd16, 3'b100},
    {4'd4,  7'b1110001, 5'd16, 3'b100}, // R4
    {4'd4,  7'b1110000, 5'd16, 3'b010},
    {4'd5,  7'b1110000, 5'd0,  3'b010},
    {4'd5,  7'b1110000, 5'd4,  3'b000},
    {4'd9,  7'b1100000, 5'd0,  3'b010}, // R9
    {4'd9,  7'b1100000, 5'd0,  3'b010},
    {4'd9,  7'b1110000, 5'd4,  3'b000},
    {4'd9,  7'b1111000, 5'd0,  3'b010},
    {4'd9,  7'b1110000, 5'd4,  3'b000},
    {4'd9,  7'b1110100, 5'd9,  3'b000},
    {4'd9,  7'b1110000, 5'd14, 3'b010},
    {4'd5,  7'b1110000, 5'd16, 3'b010},
    {4'd5,  7'b1110000, 5'd0,  3'b010},
    {4'd5,  7'b1110000, 5'd4,  3'b000},
    {4'd9,  7'b1110100, 5'd9,  3'b000},
    {4'd6,  7'b1110000, 5'd0,  3'b011}  // R6 count kept across R9
  };

  task automatic check(input int req, input logic [SSW-1:0] e_ss,
                       input logic e_d, input logic e_o, input logic e_f);
    n_chk++;
    if (ss_level !== e_ss || ss_done !== e_d || drv_off !== e_o || fault !== e_f) begin
      n_bad++;
      $display("FAIL R%0d: got ss=%0d done=%b off=%b fault=%b, want ss=%0d done=%b off=%b fault=%b",
               req, ss_level, ss_done, drv_off, fault, e_ss, e_d, e_o, e_f);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; bias_ok = 1'b1; aux_ok = 1'b1; shdn_n = 1'b1;
    inhibit = 1'b0; oc = 1'b0; ov = 1'b0; luv = 1'b0;
    step(); step();
    check(1, '0, 1'b0, 1'b1, 1'b0); // R1 reset state
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      {bias_ok, aux_ok, shdn_n, inhibit, oc, ov, luv} = VEC[k][14:8];
      step();
      check(int'(VEC[k][18:15]), VEC[k][7:3], VEC[k][2], VEC[k][1], VEC[k][0]);
      @(negedge clk);
    end
    // R8: synchronous reset clears a latched fault
    {bias_ok, aux_ok, shdn_n, inhibit, oc, ov, luv} = 7'b1110000;
    rst_n = 1'b0;
    step();
    check(8, '0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check(2, 5'd4, 1'b0, 1'b0, 1'b0); // R2 restart
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule